// File: doc/BRIEF.md
# Adaptive Voltage Level Calculator

This block derives the supply voltage codes for three reduced-load operating levels from the code of the full-load level. A code is a 6-bit index into a fixed table of 52 supply voltages, running from 747 mV at code 0 to 1342 mV at code 51. The block computes the table itself from a short arithmetic rule, so no table is stored. A start pulse captures the full-load code. The block then forms a target voltage for each reduced level. Each target is the full-load voltage lowered by a fixed drop and held at or above a 1000 mV floor.

Each target is then turned back into a code by a round-up search that examines one table entry per clock. The resulting codes are written into per-level voltage-set registers, and a one-cycle done pulse reports completion. The write happens while an internal global enable is held off and a low-voltage enable is set. An out-of-range full-load code is reported through an error flag, and the stored codes are left as they were.

Top module: `avs_level_calc`

## Requirements
- R1: After a synchronous active-low reset, all three level codes are 0 and err and done are 0.
- R2: Code k stands for 747 + 35*floor(k/3) + {0, 11, 23}[k mod 3] millivolts, for k = 0 to 51. For example, code 22 is 1003 mV and code 51 is 1342 mV.
- R3: A target maps to the lowest code whose voltage is greater than or equal to the target. If no code reaches the target, it maps to code 51.
- R4: When the full-load voltage is at or below 1000 mV, all three level codes become 22, which is the lowest code at or above 1000 mV.
- R5: Otherwise, the level-1 target is the full-load voltage minus 100 mV and the level-2/3 target is the full-load voltage minus 150 mV. Each target is raised to 1000 mV if it falls below that value.
- R6: Level 2 and level 3 always carry the same code.
- R7: A start with a full-load code of 52 or more sets err and pulses done in the cycle after the start, and leaves all three level codes unchanged. The next start with a valid code clears err.
- R8: For a valid code, done is a single-cycle pulse, and the new codes appear at the ports in the same cycle. Done rises no more than 110 cycles after the clock edge that samples start.
- R9: A start that arrives while a computation is running is ignored. The running computation uses its own code, and no extra done pulse follows.
- R10: A start presented in the cycle in which done is high is accepted and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-cycle request to compute the levels |
| l0_code | input | 6 | Full-load voltage code, sampled with start |
| lvl1_code | output | 6 | Voltage code for load level 1 |
| lvl2_code | output | 6 | Voltage code for load level 2 |
| lvl3_code | output | 6 | Voltage code for load level 3 |
| err | output | 1 | Last requested full-load code was out of range |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The completion pulse of one computation and the acceptance of the next start can occur in the same cycle. This happens because the sequencer is already idle while done is high. The bench provokes this by raising start, with a new code, on the very cycle it sees done. It first confirms that the reported codes in that cycle still belong to the first request. It then confirms that a second done follows carrying the codes for the new request, and that the first done lasted only one cycle. A start raised in the middle of a search is judged separately: the original result must be returned, and no second done may appear.

// File: rtl/avs_lvl_pkg.sv
// Package: shared constants, the computed code-to-millivolt table and the
// sequencer state type for the adaptive voltage level calculator.
// Assumes codes are 6 bits wide and voltages fit in 11 bits.
package avs_lvl_pkg;

    localparam int CODE_W     = 6;
    localparam int NUM_CODES  = 52;
    localparam int MV_W       = 11;
    localparam int NUM_LVL    = 3;
    localparam int BASE_MV    = 747;
    localparam int STEP3_MV   = 35;
    localparam int SUB1_MV    = 11;
    localparam int SUB2_MV    = 23;
    localparam int FLOOR_MV   = 1000;
    localparam int L1_DROP_MV = 100;
    localparam int L23_DROP_MV = 150;

    // Millivolt value of a code; steps repeat in groups of three codes.
    function automatic logic [MV_W-1:0] code_to_mv(input logic [CODE_W-1:0] c);
        int ci;
        int mv;
        ci = int'(c);
        mv = BASE_MV + STEP3_MV * (ci / 3);
        case (ci % 3)
            1:       mv = mv + SUB1_MV;
            2:       mv = mv + SUB2_MV;
            default: mv = mv;
        endcase
        return MV_W'(mv);
    endfunction

    // Lowest code reaching a given voltage; used for constants only.
    function automatic int first_code_at_or_above(input int mv);
        for (int k = 0; k < NUM_CODES; k++) begin
            if (int'(code_to_mv(CODE_W'(k))) >= mv) return k;
        end
        return NUM_CODES - 1;
    endfunction

    localparam int FLOOR_CODE = first_code_at_or_above(FLOOR_MV);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GO1   = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_GO2   = 3'd3,
        ST_WAIT2 = 3'd4,
        ST_PROG  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/avs_target_calc.sv
// Target calculator: turns the captured full-load code into the level-1
// and level-2/3 target voltages (fixed drops, held at the floor).
// Assumes the code is already known to be in range.
module avs_target_calc
    import avs_lvl_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int VW = MV_W
) (
    input  logic [CW-1:0] l0_code,
    output logic [VW-1:0] tgt_l1,
    output logic [VW-1:0] tgt_l23,
    output logic          at_floor
);

    localparam logic [VW-1:0] FLOOR_C = VW'(FLOOR_MV);
    localparam logic [VW-1:0] DROP1_C = VW'(L1_DROP_MV);
    localparam logic [VW-1:0] DROP23_C = VW'(L23_DROP_MV);

    logic [VW-1:0] v0;
    logic [VW-1:0] raw1;
    logic [VW-1:0] raw23;

    // Full-load voltage and the lowered targets, each held at the floor.
    always_comb begin
        v0       = code_to_mv(l0_code);
        at_floor = (v0 <= FLOOR_C);
        raw1     = v0 - DROP1_C;
        raw23    = v0 - DROP23_C;
        if (at_floor) begin
            tgt_l1  = FLOOR_C;
            tgt_l23 = FLOOR_C;
        end else begin
            tgt_l1  = (raw1  < FLOOR_C) ? FLOOR_C : raw1;
            tgt_l23 = (raw23 < FLOOR_C) ? FLOOR_C : raw23;
        end
    end

endmodule

// File: rtl/avs_code_search.sv
// Round-up searcher: on go, scans codes upward from 0, one per cycle, and
// returns the first whose voltage reaches the target, or the last code.
// Assumes go is only raised while the searcher is not busy.
module avs_code_search
    import avs_lvl_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int VW = MV_W,
    parameter int NCODES = NUM_CODES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [VW-1:0] target,
    output logic          busy,
    output logic          hit,
    output logic [CW-1:0] code
);

    localparam logic [CW-1:0] LAST_C = CW'(NCODES - 1);

    logic [CW-1:0] idx_q;
    logic [VW-1:0] tgt_q;
    logic          reached;

    // Does the entry under examination satisfy the target?
    always_comb begin
        reached = (code_to_mv(idx_q) >= tgt_q) || (idx_q == LAST_C);
    end

    // Scan state: capture target, step the index, report the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            hit   <= 1'b0;
            idx_q <= '0;
            tgt_q <= '0;
            code  <= '0;
        end else begin
            hit <= 1'b0;
            if (go && !busy) begin
                busy  <= 1'b1;
                idx_q <= '0;
                tgt_q <= target;
            end else if (busy) begin
                if (reached) begin
                    busy <= 1'b0;
                    hit  <= 1'b1;
                    code <= idx_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R3
    hit_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (code == '0 || code_to_mv(code - 1'b1) < tgt_q));

    // R3
    hit_reaches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (code_to_mv(code) >= tgt_q || code == LAST_C));

endmodule

// File: rtl/avs_vset_bank.sv
// Voltage-set register bank: one code register per load level, written
// only inside a window where the global enable is off and the low-voltage
// enable is on. Assumes open precedes wr and close follows it.
module avs_vset_bank
    import avs_lvl_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NL = NUM_LVL
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   open,
    input  logic                   wr,
    input  logic                   close,
    input  logic [NL-1:0][CW-1:0]  wr_codes,
    output logic [NL-1:0][CW-1:0]  codes
);

    logic glob_en;
    logic lowv_en;

    // Enable sequencing: open clears global enable and sets low-voltage mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            lowv_en <= 1'b0;
        end else if (open) begin
            glob_en <= 1'b0;
            lowv_en <= 1'b1;
        end else if (close) begin
            glob_en <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lvl
            // Per-level code register, loaded on write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    codes[g] <= '0;
                end else if (wr) begin
                    codes[g] <= wr_codes[g];
                end
            end
        end
    endgenerate

    // R8
    write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (!glob_en && lowv_en));

endmodule

// File: rtl/avs_level_calc.sv
// Top: sequences one shared round-up searcher over the level-1 and the
// level-2/3 targets, then programs the voltage-set bank and pulses done.
// Assumes start is a single-cycle pulse; starts while busy are dropped.
module avs_level_calc
    import avs_lvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] l0_code,
    output logic [CODE_W-1:0] lvl1_code,
    output logic [CODE_W-1:0] lvl2_code,
    output logic [CODE_W-1:0] lvl3_code,
    output logic              err,
    output logic              done
);

    localparam logic [CODE_W-1:0] NCODES_C = CODE_W'(NUM_CODES);
    localparam logic [CODE_W-1:0] FLOOR_CODE_C = CODE_W'(FLOOR_CODE);
    localparam logic [MV_W-1:0]   FLOOR_MV_C = MV_W'(FLOOR_MV);

    seq_state_t state_q;
    logic [CODE_W-1:0] l0_q;
    logic [CODE_W-1:0] c1_q;
    logic [CODE_W-1:0] c23_q;
    logic              err_q;
    logic              done_q;

    logic [MV_W-1:0]   tgt_l1;
    logic [MV_W-1:0]   tgt_l23;
    logic              at_floor;
    logic              s_go;
    logic [MV_W-1:0]   s_target;
    logic              s_busy;
    logic              s_hit;
    logic [CODE_W-1:0] s_code;
    logic              accept;
    logic              bank_open;
    logic              bank_wr;
    logic              bank_close;
    logic [NUM_LVL-1:0][CODE_W-1:0] bank_in;
    logic [NUM_LVL-1:0][CODE_W-1:0] bank_out;

    avs_target_calc #(.CW(CODE_W), .VW(MV_W)) u_tgt (
        .l0_code (l0_q),
        .tgt_l1  (tgt_l1),
        .tgt_l23 (tgt_l23),
        .at_floor(at_floor)
    );

    // Searcher request: start in a GO state, target chosen by which one.
    always_comb begin
        s_go     = (state_q == ST_GO1) || (state_q == ST_GO2);
        s_target = (state_q == ST_GO1) ? tgt_l1 : tgt_l23;
    end

    avs_code_search #(.CW(CODE_W), .VW(MV_W), .NCODES(NUM_CODES)) u_search (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (s_go),
        .target(s_target),
        .busy  (s_busy),
        .hit   (s_hit),
        .code  (s_code)
    );

    // Bank controls: open on an accepted valid start, write in PROG, close after.
    always_comb begin
        accept     = (state_q == ST_IDLE) && start;
        bank_open  = accept && (l0_code < NCODES_C);
        bank_wr    = (state_q == ST_PROG);
        bank_close = done_q && !err_q;
        bank_in    = {c23_q, c23_q, c1_q};
    end

    avs_vset_bank #(.CW(CODE_W), .NL(NUM_LVL)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .open    (bank_open),
        .wr      (bank_wr),
        .close   (bank_close),
        .wr_codes(bank_in),
        .codes   (bank_out)
    );

    // Sequencer: validate, run both searches, program, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            l0_q    <= '0;
            c1_q    <= '0;
            c23_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        l0_q <= l0_code;
                        if (l0_code >= NCODES_C) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            err_q   <= 1'b0;
                            state_q <= ST_GO1;
                        end
                    end
                end
                ST_GO1:   state_q <= ST_WAIT1;
                ST_WAIT1: begin
                    if (s_hit) begin
                        c1_q    <= s_code;
                        state_q <= ST_GO2;
                    end
                end
                ST_GO2:   state_q <= ST_WAIT2;
                ST_WAIT2: begin
                    if (s_hit) begin
                        c23_q   <= s_code;
                        state_q <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign lvl1_code = bank_out[0];
    assign lvl2_code = bank_out[1];
    assign lvl3_code = bank_out[2];
    assign err       = err_q;
    assign done      = done_q;

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> $stable(l0_q));

    // R7
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && l0_code >= NCODES_C) |=> (done && err));

    // R4
    floor_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && at_floor) |-> (c1_q == FLOOR_CODE_C && c23_q == FLOOR_CODE_C));

    // R5
    l1_above_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> (code_to_mv(c1_q) >= FLOOR_MV_C && c1_q >= c23_q));

    // R8
    searcher_idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !s_busy);

endmodule

// File: tb/avs_level_calc_test.sv
// Bench: vector table walked by one loop, then directed corner cases.
module avs_level_calc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] l0_code = '0;
    logic [5:0] lvl1_code;
    logic [5:0] lvl2_code;
    logic [5:0] lvl3_code;
    logic       err;
    logic       done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    avs_level_calc uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .l0_code  (l0_code),
        .lvl1_code(lvl1_code),
        .lvl2_code(lvl2_code),
        .lvl3_code(lvl3_code),
        .err      (err),
        .done     (done)
    );

    // {full-load code, expected level-1 code, expected level-2/3 code}
    localparam logic [17:0] VEC [8] = '{
        {6'd0,  6'd22, 6'd22},
        {6'd21, 6'd22, 6'd22},
        {6'd22, 6'd22, 6'd22},
        {6'd30, 6'd22, 6'd22},
        {6'd31, 6'd23, 6'd22},
        {6'd40, 6'd32, 6'd28},
        {6'd45, 6'd37, 6'd33},
        {6'd51, 6'd43, 6'd39}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [5:0] code);
        start   = 1'b1;
        l0_code = code;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // Waits at negedges for done; returns cycles waited, or -1 on timeout.
    task automatic wait_done(output int cycles);
        cycles = -1;
        for (int n = 1; n <= 200; n++) begin
            if (done) begin
                cycles = n - 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_codes(input string req, input int e1, input int e23);
        check({req, " lvl1"}, lvl1_code, e1);
        check({req, " lvl2"}, lvl2_code, e23);
        check({req, " lvl3"}, lvl3_code, e23);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int extra;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 lvl1", lvl1_code, 0);
        check("R1 lvl2", lvl2_code, 0);
        check("R1 lvl3", lvl3_code, 0);
        check("R1 err", err, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: table walk
        foreach (VEC[i]) begin
            pulse_start(VEC[i][17:12]);
            wait_done(lat);
            check("R8 latency bound", (lat >= 0 && lat <= 110) ? 1 : 0, 1);
            if (VEC[i][17:12] <= 6'd21) check_codes("R4", VEC[i][11:6], VEC[i][5:0]);
            else check_codes("R5 R3 R2", VEC[i][11:6], VEC[i][5:0]);
            check("R6 lvl2 eq lvl3", lvl2_code, lvl3_code);
            check("R7 err clear", err, 0);
            @(negedge clk);
            check("R8 done single", done, 0);
        end

        // R7 invalid codes leave levels unchanged (last valid: 43/39)
        pulse_start(6'd52);
        check("R7 done next cycle", done, 1);
        check("R7 err set", err, 1);
        check_codes("R7 unchanged", 43, 39);
        @(negedge clk);
        pulse_start(6'd63);
        check("R7 err 63", err, 1);
        check_codes("R7 unchanged 63", 43, 39);
        @(negedge clk);
        pulse_start(6'd40);
        wait_done(lat);
        check("R7 err cleared", err, 0);
        check_codes("R7 recovery", 32, 28);
        @(negedge clk);

        // R9 start during busy is ignored
        pulse_start(6'd31);
        repeat (5) @(negedge clk);
        pulse_start(6'd63);
        wait_done(lat);
        check("R9 done seen", (lat >= 0) ? 1 : 0, 1);
        check("R9 no err", err, 0);
        check_codes("R9", 23, 22);
        extra = 0;
        for (int n = 0; n < 120; n++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R9 no extra done", extra, 0);

        // R10 start in the done cycle is accepted
        pulse_start(6'd45);
        wait_done(lat);
        check_codes("R10 first", 37, 33);
        start   = 1'b1;
        l0_code = 6'd22;
        @(negedge clk);
        start   = 1'b0;
        check("R8 R10 done dropped", done, 0);
        wait_done(lat);
        check("R10 second done", (lat >= 0) ? 1 : 0, 1);
        check_codes("R10 second", 22, 22);
        @(negedge clk);

        // R1 reset in the middle of a run
        pulse_start(6'd51);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_codes("R1 mid-run reset", 0, 0);
        extra = 0;
        for (int n = 0; n < 120; n++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R1 no done after reset", extra, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule